// File: doc/BRIEF.md
# Byte-to-Word Receive FIFO

This block sits between a serial receiver and a processor read port. Bytes arrive one at a time with a valid strobe. They are packed into 32-bit words, and each word carries a count of how many of its four byte lanes hold received data. Committed words wait in an eight-entry store. The head word and its count are always visible at the read port, so software knows before the read how many bytes the word will yield.

An endian select decides which lane each incoming byte takes. In big endian order the first byte of a word goes to the most significant lane. In little endian order it goes to the least significant lane. A word is committed as soon as its fourth byte lands. A shorter word is committed after a programmable number of idle cycles with no new byte, so that a short message still reaches the processor.

A ready flag reports that a committed word is waiting, and it raises an interrupt when the enable is set. A byte that arrives while the store is full is discarded and sets an overrun flag. That flag stays set until reset.

Top module: `rx_word_fifo`

## Requirements
- R1: After reset, rd_count_o is 0, rd_data_o is 0, ready_o is 0, irq_o is 0 and overrun_o is 0.
- R2: With big_endian_i low, the k-th byte of a word (k = 0..3, in arrival order) is placed in bits [8k+7:8k].
- R3: With big_endian_i high, the k-th byte of a word is placed in bits [31-8k:24-8k].
- R4: The fourth byte of a word commits the word at the same clock edge that captures it, so ready_o is high in the following cycle with rd_count_o = 4.
- R5: A word holding 1 to 3 bytes is committed at the clock edge idle_limit_i+1 edges after its last byte was captured, provided no byte arrives in between. It reads with rd_count_o equal to its byte count, and its unused lanes read as zero.
- R6: rd_data_o and rd_count_o show the oldest committed word. A cycle with rd_i high pops that word. When no word is committed, rd_count_o is 0 (3-bit field, values 0 to 4), rd_data_o is 0, and rd_i has no effect.
- R7: ready_o is high exactly when at least one committed word is stored, and irq_o equals ready_o AND irq_en_i.
- R8: The store holds 8 words. A byte arriving while all 8 are held is discarded and never appears in any later word, the stored words stay intact, and overrun_o goes high and stays high until reset.
- R9: Committed words are read back in the order they were committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| big_endian_i | input | 1 | 1: first byte to the most significant lane; 0: first byte to the least significant lane |
| idle_limit_i | input | IDLE_W (16) | Idle cycles before a partial word is committed |
| rd_i | input | 1 | Pop the head word |
| irq_en_i | input | 1 | Interrupt enable |
| rd_data_o | output | 32 | Head word, zero when empty |
| rd_count_o | output | 3 | Valid bytes in head word, 0 when empty |
| ready_o | output | 1 | A committed word is available |
| irq_o | output | 1 | Interrupt request |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench packs words of one to four bytes in both byte orders. A lane index computed the wrong way round would show up as mirrored words, and failing to clear unused lanes would leave stale bytes from the previous word in them. It also checks the exact edge at which a partial word is released: an idle counter that is off by one would commit the word a cycle early or late. Reading an empty store must leave the next word untouched, or the bench sees a lost or corrupted word. Filling all eight entries and then sending one more byte exposes a design that lets the extra byte overwrite a stored word, or that slips it into the next word after space frees up.

// File: rtl/rx_word_pkg.sv
package rx_word_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WORD_W = BYTE_W * LANES;
  localparam int unsigned CNT_W  = $clog2(LANES + 1);

  typedef struct packed {
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] data;
  } word_t;
endpackage

// File: rtl/rx_word_packer.sv
module rx_word_packer
  import rx_word_pkg::*;
#(
  parameter int unsigned IDLE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              big_endian_i,
  input  logic [IDLE_W-1:0] idle_limit_i,
  input  logic              full_i,
  output logic              push_o,
  output word_t             push_word_o,
  output logic              drop_o
);
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

  logic [WORD_W-1:0] acc_q, acc_ins;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDLE_W-1:0] idle_q;
  logic [LANE_W-1:0] lane;
  logic accept, full_word, idle_flush;

  assign accept = byte_valid_i & ~full_i;
  assign drop_o = byte_valid_i & full_i;
  assign lane   = big_endian_i ? LANE_W'(LAST - cnt_q) : cnt_q[LANE_W-1:0];

  always_comb begin
    acc_ins = acc_q;
    for (int i = 0; i < int'(LANES); i++)
      if (accept && lane == LANE_W'(i)) acc_ins[i*BYTE_W +: BYTE_W] = byte_i;
  end

  assign full_word  = accept && cnt_q == LAST;
  assign idle_flush = !accept && !full_i && cnt_q != '0 && idle_q == idle_limit_i;
  assign push_o     = full_word | idle_flush;

  always_comb begin
    push_word_o.data = full_word ? acc_ins : acc_q;
    push_word_o.cnt  = full_word ? CNT_W'(LANES) : cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      idle_q <= '0;
    end else if (push_o) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      idle_q <= '0;
    end else if (accept) begin
      acc_q  <= acc_ins;
      cnt_q  <= cnt_q + 1'b1;
      idle_q <= '0;
    end else if (cnt_q != '0 && idle_q != idle_limit_i) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  // R5
  push_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (push_word_o.cnt != '0 && push_word_o.cnt <= CNT_W'(LANES)));

  // R8
  drop_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> !push_o);
endmodule

// File: rtl/rx_word_store.sv
module rx_word_store
  import rx_word_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  word_t push_word_i,
  input  logic  pop_i,
  output word_t head_o,
  output logic  empty_o,
  output logic  full_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  word_t          mem [DEPTH];
  logic [PTR_W:0] wr_q, rd_q;
  logic           do_push, do_pop;

  assign empty_o = wr_q == rd_q;
  assign full_o  = (wr_q[PTR_W] != rd_q[PTR_W]) && (wr_q[PTR_W-1:0] == rd_q[PTR_W-1:0]);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign head_o  = empty_o ? '0 : mem[rd_q[PTR_W-1:0]];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q[PTR_W-1:0]] <= push_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  // R6
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> $stable(rd_q));
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
  import rx_word_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned IDLE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              big_endian_i,
  input  logic [IDLE_W-1:0] idle_limit_i,
  input  logic              rd_i,
  input  logic              irq_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  rd_count_o,
  output logic              ready_o,
  output logic              irq_o,
  output logic              overrun_o
);
  logic  push, drop, empty, full;
  word_t push_word, head;
  logic  overrun_q;

  rx_word_packer #(.IDLE_W(IDLE_W)) u_packer (
    .clk_i, .rst_ni, .byte_valid_i, .byte_i, .big_endian_i, .idle_limit_i,
    .full_i(full), .push_o(push), .push_word_o(push_word), .drop_o(drop)
  );

  rx_word_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .push_i(push), .push_word_i(push_word), .pop_i(rd_i),
    .head_o(head), .empty_o(empty), .full_o(full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   overrun_q <= 1'b0;
    else if (drop) overrun_q <= 1'b1;
  end

  assign rd_data_o  = head.data;
  assign rd_count_o = head.cnt;
  assign ready_o    = ~empty;
  assign irq_o      = ready_o & irq_en_i;
  assign overrun_o  = overrun_q;

  // R8
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  // R6
  count_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> rd_count_o != '0);
endmodule

// File: tb/rx_word_fifo_bench.sv
module rx_word_fifo_bench;
  localparam int CLK_P = 10;
  localparam int IDLE  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bv = 1'b0;
  logic [7:0]  bd = '0;
  logic        be = 1'b0;
  logic [15:0] idle_lim = 16'(IDLE);
  logic        rd = 1'b0;
  logic        ien = 1'b0;
  logic [31:0] rdata;
  logic [2:0]  rcnt;
  logic        rdy, irq, ovr;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_word_fifo u_rx_word_fifo (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .byte_i(bd),
    .big_endian_i(be), .idle_limit_i(idle_lim), .rd_i(rd), .irq_en_i(ien),
    .rd_data_o(rdata), .rd_count_o(rcnt), .ready_o(rdy), .irq_o(irq),
    .overrun_o(ovr)
  );

  // {big_endian, nbytes, bytes (first in [7:0]), expected word}
  localparam logic [67:0] VEC [7] = '{
    {1'b0, 3'd4, 32'h44332211, 32'h44332211},
    {1'b1, 3'd4, 32'h44332211, 32'h11223344},
    {1'b0, 3'd1, 32'h000000A5, 32'h000000A5},
    {1'b1, 3'd1, 32'h000000A5, 32'hA5000000},
    {1'b0, 3'd3, 32'h00CCBBAA, 32'h00CCBBAA},
    {1'b1, 3'd2, 32'h00003C5A, 32'h5A3C0000},
    {1'b1, 3'd3, 32'h00030201, 32'h01020300}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    bv = 1'b1; bd = b;
    @(negedge clk);
    bv = 1'b0;
  endtask

  task automatic pop();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    // R1
    check("R1 count", 32'(rcnt), 0);
    check("R1 data", rdata, 0);
    check("R1 flags", {29'd0, rdy, irq, ovr}, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 R3 R5 table walk
    foreach (VEC[v]) begin
      be = VEC[v][67];
      for (int k = 0; k < int'(VEC[v][66:64]); k++) put(VEC[v][32 + 8*k +: 8]);
      idle(IDLE + 2);
      check(VEC[v][67] ? "R3 count" : "R2 count", 32'(rcnt), 32'(VEC[v][66:64]));
      check(VEC[v][67] ? "R3 word" : "R2 word", rdata, VEC[v][31:0]);
      pop();
      check("R6 empty after pop", 32'(rcnt), 0);
    end

    // R4 full word ready at once
    be = 1'b0;
    put(8'h01); put(8'h02); put(8'h03); put(8'h04);
    check("R4 ready", 32'(rdy), 1);
    check("R4 count", 32'(rcnt), 4);
    pop();

    // R5 exact idle release edge
    put(8'h77); put(8'h88);
    idle(IDLE);
    check("R5 not yet", 32'(rdy), 0);
    idle(1);
    check("R5 released", 32'(rdy), 1);
    check("R5 word", rdata, 32'h00008877);
    pop();

    // R6 read while empty
    check("R6 empty data", rdata, 0);
    pop();
    put(8'h9C);
    idle(IDLE + 2);
    check("R6 after empty read", {rdata[7:0], 5'd0, rcnt}, {8'h9C, 8'd1});
    // R7
    check("R7 irq off", 32'(irq), 0);
    ien = 1'b1;
    #1 check("R7 irq on", 32'(irq), 1);
    pop();
    check("R7 irq clears", {30'd0, rdy, irq}, 0);
    ien = 1'b0;

    // R8 R9 fill 8 words, then one byte extra
    for (int w = 0; w < 8; w++)
      for (int j = 0; j < 4; j++) put(8'(w*4 + j));
    check("R8 no overrun yet", 32'(ovr), 0);
    put(8'hEE);
    check("R8 overrun", 32'(ovr), 1);
    for (int w = 0; w < 8; w++) begin
      check("R9 order", rdata,
            {8'(w*4+3), 8'(w*4+2), 8'(w*4+1), 8'(w*4)});
      pop();
    end
    idle(IDLE + 3);
    check("R8 dropped byte absent", 32'(rcnt), 0);
    check("R8 overrun sticky", 32'(ovr), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule